// File: doc/BRIEF.md
# Octant-Folded Sine/Cosine Lookup

This block turns an unsigned phase word into a pair of two's complement samples, one sine and one cosine. Its lookup table spans only the first eighth of a cycle (angles from zero up to, but excluding, π/4). Every other angle is rebuilt from that table. The three most significant phase bits name the octant. In odd octants the residual angle is mirrored, and the two table values are then swapped and negated as the octant needs.

A phase accumulator sits upstream and feeds the block one phase word per clock, with a valid strobe. The block is a fixed three-stage pipeline: fold, table read, then sign and swap. A clock enable stalls all three stages together. The table contents are computed while the design is elaborated, so no memory image file is needed.

Top module: `sc_octant_lut`

## Requirements
- R1: The octant is `phase_i[PHASE_W-1:PHASE_W-3]`. The residual `r` is the remaining `PHASE_W-3` bits. In even octants (0, 2, 4, 6) the table is indexed by `r` directly, so the output matches the ideal sample at the input phase.
- R2: In odd octants (1, 3, 5, 7) the table index is the bitwise complement of `r`. The output therefore matches the ideal sample at input phase + 1 (modulo 2^PHASE_W).
- R3: Let S and C be the stored sine and cosine magnitudes at the index. Octants 0 to 7 give (sin, cos) = (S,C), (C,S), (C,−S), (S,−C), (−S,−C), (−C,−S), (−C,S), (−S,C). The sine is non-positive in octants 4 to 7. The cosine is non-positive in octants 2 to 5.
- R4: The peak amplitude is A = 2^(MAG_W-1)−1, and no output lies outside ±A. Phase 0 gives cos = +A. A quarter cycle gives sin = +A. A half cycle gives cos = −A. Three quarters gives sin = −A.
- R5: With the clock enable held high, `valid_o` and the samples for an input appear on the third rising edge after the input is presented. Inputs presented on consecutive cycles come out on consecutive cycles.
- R6: While `ce_i` is low, no stage advances. `valid_o`, `sin_o` and `cos_o` hold their values whatever the inputs do.
- R7: When `rst_ni` is low, `valid_o`, `sin_o` and `cos_o` are cleared to zero at once, without waiting for a clock edge.
- R8: The table holds 2^(PHASE_W-3) entries per function. Entry i is round(A·sin(i·π/4 / 2^(PHASE_W-3))), and likewise for cosine. Every phase in a full sweep maps onto the ideal waveform within one LSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ce_i | input | 1 | Clock enable for all pipeline stages |
| valid_i | input | 1 | Phase word is valid |
| phase_i | input | PHASE_W | Unsigned phase, full cycle = 2^PHASE_W |
| valid_o | output | 1 | Samples are valid |
| sin_o | output | MAG_W | Sine sample, two's complement |
| cos_o | output | MAG_W | Cosine sample, two's complement |

## Verification
A clock-enable stall can land while a valid sample is part-way through the pipeline. The hold behaviour and the three-cycle latency then act in the same cycles. The bench provokes this in two ways. First, it lets one stage capture a sample and then drops `ce_i` for several cycles. Second, it freezes a valid output while new phase words are driven at the input. It judges the result by the exact edge on which `valid_o` rises after the enable returns, and by whether the held output survives unchanged. A further case drives an octant boundary, where the complemented index and the swap/negate map change on the same sample. Phases such as one step below a quarter cycle must land exactly on the full-scale value.

// File: rtl/sc_fold_pkg.sv
package sc_fold_pkg;

  typedef logic [2:0] octant_t;

  localparam real QTR_PI = 0.785398163397448309616;

  // rounded magnitude of sin or cos at idx steps of (pi/4)/2^r_w
  function automatic longint quarter_val(longint idx, int r_w, int mag_w, bit want_cos);
    real amp;
    real th;
    real v;
    amp = (2.0 ** (mag_w - 1)) - 1.0;
    th  = (real'(idx) * QTR_PI) / (2.0 ** r_w);
    v   = want_cos ? amp * $cos(th) : amp * $sin(th);
    return longint'($floor(v + 0.5));
  endfunction

  function automatic logic oct_swap(octant_t o);
    return o[0] ^ o[1];
  endfunction

  function automatic logic oct_sin_neg(octant_t o);
    return o[2];
  endfunction

  function automatic logic oct_cos_neg(octant_t o);
    return o[2] ^ o[1];
  endfunction

endpackage

// File: rtl/sc_fold_stage.sv
module sc_fold_stage
  import sc_fold_pkg::*;
#(
  parameter int PHASE_W = 10,
  localparam int R_W = PHASE_W - 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ce_i,
  input  logic               valid_i,
  input  logic [PHASE_W-1:0] phase_i,
  output logic               valid_o,
  output octant_t            oct_o,
  output logic [R_W-1:0]     idx_o
);

  octant_t        oct_in;
  logic [R_W-1:0] res_in;
  logic [R_W-1:0] idx_d;

  assign oct_in = phase_i[PHASE_W-1 -: 3];
  assign res_in = phase_i[R_W-1:0];
  // odd octant: mirror residual so the table is read from pi/4 downwards
  assign idx_d  = oct_in[0] ? ~res_in : res_in;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      oct_o   <= '0;
      idx_o   <= '0;
    end else if (ce_i) begin
      valid_o <= valid_i;
      oct_o   <= oct_in;
      idx_o   <= idx_d;
    end
  end

endmodule

// File: rtl/sc_quarter_rom.sv
module sc_quarter_rom
  import sc_fold_pkg::*;
#(
  parameter int R_W   = 7,
  parameter int MAG_W = 12,
  localparam int DEPTH = 1 << R_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ce_i,
  input  logic             valid_i,
  input  octant_t          oct_i,
  input  logic [R_W-1:0]   idx_i,
  output logic             valid_o,
  output octant_t          oct_o,
  output logic [MAG_W-1:0] sin_q_o,
  output logic [MAG_W-1:0] cos_q_o
);

  logic [MAG_W-1:0] sin_tab [DEPTH];
  logic [MAG_W-1:0] cos_tab [DEPTH];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_tab
    localparam longint SV = quarter_val(longint'(gi), R_W, MAG_W, 1'b0);
    localparam longint CV = quarter_val(longint'(gi), R_W, MAG_W, 1'b1);
    assign sin_tab[gi] = MAG_W'(SV);
    assign cos_tab[gi] = MAG_W'(CV);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      oct_o   <= '0;
      sin_q_o <= '0;
      cos_q_o <= '0;
    end else if (ce_i) begin
      valid_o <= valid_i;
      oct_o   <= oct_i;
      sin_q_o <= sin_tab[idx_i];
      cos_q_o <= cos_tab[idx_i];
    end
  end

endmodule

// File: rtl/sc_sign_swap.sv
module sc_sign_swap
  import sc_fold_pkg::*;
#(
  parameter int MAG_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ce_i,
  input  logic             valid_i,
  input  octant_t          oct_i,
  input  logic [MAG_W-1:0] sin_q_i,
  input  logic [MAG_W-1:0] cos_q_i,
  output logic             valid_o,
  output logic [MAG_W-1:0] sin_o,
  output logic [MAG_W-1:0] cos_o
);

  localparam logic [MAG_W-1:0] MOST_NEG = {1'b1, {(MAG_W-1){1'b0}}};
  localparam logic [MAG_W-1:0] MOST_POS = {1'b0, {(MAG_W-1){1'b1}}};

  function automatic logic [MAG_W-1:0] neg_sat(logic [MAG_W-1:0] x);
    return (x == MOST_NEG) ? MOST_POS : (~x + 1'b1);
  endfunction

  logic [MAG_W-1:0] sin_pre, cos_pre, sin_d, cos_d;

  always_comb begin
    if (oct_swap(oct_i)) begin
      sin_pre = cos_q_i;
      cos_pre = sin_q_i;
    end else begin
      sin_pre = sin_q_i;
      cos_pre = cos_q_i;
    end
    sin_d = oct_sin_neg(oct_i) ? neg_sat(sin_pre) : sin_pre;
    cos_d = oct_cos_neg(oct_i) ? neg_sat(cos_pre) : cos_pre;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      sin_o   <= '0;
      cos_o   <= '0;
    end else if (ce_i) begin
      valid_o <= valid_i;
      sin_o   <= sin_d;
      cos_o   <= cos_d;
    end
  end

endmodule

// File: rtl/sc_octant_lut.sv
module sc_octant_lut
  import sc_fold_pkg::*;
#(
  parameter int PHASE_W = 10,
  parameter int MAG_W   = 12,
  localparam int R_W    = PHASE_W - 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ce_i,
  input  logic               valid_i,
  input  logic [PHASE_W-1:0] phase_i,
  output logic               valid_o,
  output logic [MAG_W-1:0]   sin_o,
  output logic [MAG_W-1:0]   cos_o
);

  logic             v1, v2;
  octant_t          oct1, oct2;
  logic [R_W-1:0]   idx1;
  logic [MAG_W-1:0] sin_q, cos_q;

  sc_fold_stage #(.PHASE_W(PHASE_W)) u_fold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ce_i    (ce_i),
    .valid_i (valid_i),
    .phase_i (phase_i),
    .valid_o (v1),
    .oct_o   (oct1),
    .idx_o   (idx1)
  );

  sc_quarter_rom #(.R_W(R_W), .MAG_W(MAG_W)) u_rom (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ce_i    (ce_i),
    .valid_i (v1),
    .oct_i   (oct1),
    .idx_i   (idx1),
    .valid_o (v2),
    .oct_o   (oct2),
    .sin_q_o (sin_q),
    .cos_q_o (cos_q)
  );

  sc_sign_swap #(.MAG_W(MAG_W)) u_sign (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ce_i    (ce_i),
    .valid_i (v2),
    .oct_i   (oct2),
    .sin_q_i (sin_q),
    .cos_q_i (cos_q),
    .valid_o (valid_o),
    .sin_o   (sin_o),
    .cos_o   (cos_o)
  );

endmodule

// File: rtl/sc_octant_lut_chk.sv
module sc_octant_lut_chk #(
  parameter int MAG_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ce_i,
  input logic             valid_i,
  input logic [2:0]       oct_top_i,
  input logic             valid_o,
  input logic [MAG_W-1:0] sin_o,
  input logic [MAG_W-1:0] cos_o
);

  localparam logic signed [MAG_W-1:0] AMP = {1'b0, {(MAG_W-1){1'b1}}};

  // consecutive enabled edges since reset, saturating at 3
  logic [1:0] run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          run_q <= '0;
    else if (!ce_i)       run_q <= '0;
    else if (run_q != 2'd3) run_q <= run_q + 2'd1;
  end

  logic sin_neg_in, cos_neg_in;
  assign sin_neg_in = oct_top_i[2];
  assign cos_neg_in = oct_top_i[2] ^ oct_top_i[1];

  p_latency_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q == 2'd3) |-> (valid_o == $past(valid_i, 3)));

  p_sin_sign_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q == 2'd3 && valid_o) |->
      ($past(sin_neg_in, 3) ? ($signed(sin_o) <= 0) : ($signed(sin_o) >= 0)));

  p_cos_sign_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q == 2'd3 && valid_o) |->
      ($past(cos_neg_in, 3) ? ($signed(cos_o) <= 0) : ($signed(cos_o) >= 0)));

  p_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($signed(sin_o) >= -AMP) && ($signed(sin_o) <= AMP) &&
    ($signed(cos_o) >= -AMP) && ($signed(cos_o) <= AMP));

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_i |=> ($stable(valid_o) && $stable(sin_o) && $stable(cos_o)));

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      p_reset_r7: assert (!valid_o && sin_o == '0 && cos_o == '0);
    end
  end

endmodule

bind sc_octant_lut sc_octant_lut_chk #(.MAG_W(MAG_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ce_i      (ce_i),
  .valid_i   (valid_i),
  .oct_top_i (phase_i[PHASE_W-1 -: 3]),
  .valid_o   (valid_o),
  .sin_o     (sin_o),
  .cos_o     (cos_o)
);

// File: tb/sim_sc_octant_lut.sv
module sim_sc_octant_lut;

  localparam int PHASE_W = 10;
  localparam int MAG_W   = 12;
  localparam int FULL    = 1 << PHASE_W;
  localparam int OCT_SH  = PHASE_W - 3;
  localparam int AMP     = (1 << (MAG_W - 1)) - 1;
  localparam int NVEC    = 20;

  // {input phase, phase of the ideal sample expected at the output}
  localparam int VEC [NVEC][2] = '{
    '{0, 0},     '{37, 37},   '{127, 127}, '{128, 129}, '{200, 201},
    '{255, 256}, '{256, 256}, '{300, 300}, '{384, 385}, '{450, 451},
    '{511, 512}, '{512, 512}, '{600, 600}, '{640, 641}, '{700, 701},
    '{768, 768}, '{800, 800}, '{896, 897}, '{1000, 1001}, '{1023, 1024}
  };

  logic               clk = 1'b0;
  logic               rst_ni = 1'b0;
  logic               ce_i = 1'b1;
  logic               valid_i = 1'b0;
  logic [PHASE_W-1:0] phase_i = '0;
  logic               valid_o;
  logic [MAG_W-1:0]   sin_o, cos_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  sc_octant_lut #(.PHASE_W(PHASE_W), .MAG_W(MAG_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .ce_i(ce_i), .valid_i(valid_i),
    .phase_i(phase_i), .valid_o(valid_o), .sin_o(sin_o), .cos_o(cos_o)
  );

  function automatic int ideal(int eff, bit want_cos);
    real th;
    real v;
    th = 2.0 * 3.14159265358979323846 * real'(eff) / real'(FULL);
    v  = real'(AMP) * (want_cos ? $cos(th) : $sin(th));
    return (v >= 0.0) ? int'($floor(v + 0.5)) : -int'($floor(-v + 0.5));
  endfunction

  function automatic int eff_of(int p);
    return ((p >> OCT_SH) & 1) ? p + 1 : p;
  endfunction

  task automatic chk(string req, int act, int exp, int tol);
    int d;
    n_tests++;
    d = act - exp;
    if (d < 0) d = -d;
    if (d > tol) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int s_of(logic [MAG_W-1:0] x);
    return int'($signed(x));
  endfunction

  task automatic tick(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // single sample, ce high, returns after the output stage has loaded it
  task automatic one_shot(int p);
    valid_i = 1'b1;
    phase_i = PHASE_W'(p);
    tick(1);
    valid_i = 1'b0;
    tick(2);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int bad_rng;
    int bad_val;
    tick(2);
    // R7 reset state
    chk("R7 valid in reset", int'(valid_o), 0, 0);
    chk("R7 sin in reset", s_of(sin_o), 0, 0);
    chk("R7 cos in reset", s_of(cos_o), 0, 0);
    rst_ni = 1'b1;
    tick(1);

    // vector table streamed back to back: R1/R2/R3 values, R5 throughput
    for (int i = 0; i < NVEC + 3; i++) begin
      if (i >= 3) begin
        chk("R5 valid in stream", int'(valid_o), 1, 0);
        chk(((VEC[i-3][0] >> OCT_SH) & 1) ? "R2 R3 sin" : "R1 R3 sin",
            s_of(sin_o), ideal(VEC[i-3][1], 1'b0), 1);
        chk(((VEC[i-3][0] >> OCT_SH) & 1) ? "R2 R3 cos" : "R1 R3 cos",
            s_of(cos_o), ideal(VEC[i-3][1], 1'b1), 1);
      end
      if (i < NVEC) begin
        valid_i = 1'b1;
        phase_i = PHASE_W'(VEC[i][0]);
      end else begin
        valid_i = 1'b0;
      end
      tick(1);
    end
    chk("R5 valid drops after stream", int'(valid_o), 0, 0);

    // R5 exact latency from idle
    valid_i = 1'b1; phase_i = '0;
    tick(1);
    valid_i = 1'b0;
    chk("R5 not valid after 1 edge", int'(valid_o), 0, 0);
    tick(1);
    chk("R5 not valid after 2 edges", int'(valid_o), 0, 0);
    tick(1);
    chk("R5 valid after 3 edges", int'(valid_o), 1, 0);
    chk("R4 cos at phase 0", s_of(cos_o), AMP, 0);
    chk("R4 sin at phase 0", s_of(sin_o), 0, 0);
    tick(1);
    chk("R5 single pulse width", int'(valid_o), 0, 0);

    // R4 exact full-scale points
    one_shot(FULL / 4);
    chk("R4 sin at quarter", s_of(sin_o), AMP, 0);
    one_shot(FULL / 4 - 1);
    chk("R2 R4 sin one below quarter", s_of(sin_o), AMP, 0);
    chk("R2 cos one below quarter", s_of(cos_o), 0, 0);
    one_shot(FULL / 2);
    chk("R4 cos at half", s_of(cos_o), -AMP, 0);
    one_shot(3 * FULL / 4);
    chk("R4 sin at three quarters", s_of(sin_o), -AMP, 0);

    // R6 stall with a sample inside the pipe
    tick(2);
    valid_i = 1'b1; phase_i = PHASE_W'(FULL / 4);
    tick(1);
    valid_i = 1'b0; ce_i = 1'b0;
    tick(5);
    chk("R6 no output during stall", int'(valid_o), 0, 0);
    ce_i = 1'b1;
    tick(1);
    chk("R6 R5 still in pipe after resume 1", int'(valid_o), 0, 0);
    tick(1);
    chk("R6 R5 emerges after resume 2", int'(valid_o), 1, 0);
    chk("R6 sample survives stall", s_of(sin_o), AMP, 0);
    // R6 hold a valid output while inputs change
    ce_i = 1'b0; valid_i = 1'b1; phase_i = PHASE_W'(FULL / 2);
    tick(4);
    chk("R6 valid held", int'(valid_o), 1, 0);
    chk("R6 sin held", s_of(sin_o), AMP, 0);
    chk("R6 cos held", s_of(cos_o), 0, 0);
    ce_i = 1'b1;
    tick(1);
    valid_i = 1'b0;
    tick(2);
    chk("R6 R4 resumed sample cos", s_of(cos_o), -AMP, 0);

    // R8/R4 full sweep of every phase
    bad_rng = 0; bad_val = 0;
    for (int i = 0; i < FULL + 3; i++) begin
      if (i >= 3) begin
        if (s_of(sin_o) > AMP || s_of(sin_o) < -AMP ||
            s_of(cos_o) > AMP || s_of(cos_o) < -AMP) bad_rng++;
        if ((s_of(sin_o) - ideal(eff_of(i-3), 1'b0)) > 1 ||
            (ideal(eff_of(i-3), 1'b0) - s_of(sin_o)) > 1 ||
            (s_of(cos_o) - ideal(eff_of(i-3), 1'b1)) > 1 ||
            (ideal(eff_of(i-3), 1'b1) - s_of(cos_o)) > 1 ||
            !valid_o) bad_val++;
      end
      valid_i = (i < FULL);
      phase_i = PHASE_W'(i);
      tick(1);
    end
    valid_i = 1'b0;
    chk("R4 sweep range violations", bad_rng, 0, 0);
    chk("R8 sweep value mismatches", bad_val, 0, 0);

    // R7 asynchronous reset mid-run
    one_shot(0);
    #5 rst_ni = 1'b0;
    #1;
    chk("R7 async clear valid", int'(valid_o), 0, 0);
    chk("R7 async clear cos", s_of(cos_o), 0, 0);
    tick(1);
    rst_ni = 1'b1;
    tick(3);
    chk("R7 stays idle after release", int'(valid_o), 0, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule